// File: doc/BRIEF.md
# CAN Fault Confinement Tracker

This block follows the health of a CAN node. The protocol engine sends it one-cycle pulses: an error seen on the bus (with a type code and a flag saying whether the node was transmitting), a frame sent cleanly, a frame received cleanly, a lost message and a mailbox event. From these pulses the block keeps a transmit error count and a receive error count. It derives one of four confinement levels from the two counts: active, warning, passive or bus-off.

Software sees the result through a small word-wide register port. One status word holds sticky bits, one per error type, plus bits for the levels reached. The two counts can be read from their own addresses. An interrupt flag word has a matching mask word, and a single interrupt line is driven from the flags that the mask enables.

Once the node goes bus-off, counting stops and every interrupt source is masked at once. The node stays bus-off until the engine raises a recovery request.

Top module: `can_fault_tracker`

## Requirements
- R1: After reset both counters are 0, `fault_state` is 0, and the status, flag and mask words read 0. `irq` is 0.
- R2: A transmit error (`err_evt` with `err_is_tx`=1) adds 8 to the transmit count. `tx_ok` subtracts 1 and stops at 0. In a cycle with `err_evt` high, `tx_ok` and `rx_ok` are ignored.
- R3: A receive error (`err_evt` with `err_is_tx`=0) adds 1 to the receive count and saturates at 511. `rx_ok` subtracts 1 and stops at 0.
- R4: `fault_state` encodes the level: 3 means bus-off. Otherwise it is 2 when either count is 128 or more, and 1 when either count is 96 or more. In all other cases it is 0.
- R5: A transmit error that takes the transmit count above 255 enters bus-off. While bus-off, error and success pulses change nothing. A `recover_req` pulse while bus-off clears both counts and returns the level to 0. Outside bus-off, `recover_req` has no effect.
- R6: Status word (address 0) error bits: each error pulse sets a sticky bit chosen by `err_code`. Code 0 (form) sets bit 24, code 1 (bit) sets bit 23, code 2 (stuck dominant) sets bit 22, code 3 (CRC) sets bit 21, code 4 (stuff) sets bit 20 and code 5 (acknowledge) sets bit 19. Codes 6 and 7 set no bit.
- R7: Status bit 16 (warning or worse), bit 17 (passive or worse) and bit 18 (bus-off) are set whenever that level holds. Writing 1 to any of status bits 16 to 24 clears that bit. A bit whose condition still holds stays set.
- R8: Address 1 returns the transmit count and address 2 returns the receive count, both zero-extended. Writes to these two addresses change nothing. Addresses 5 to 7 read 0.
- R9: Flag word (address 3) uses bit 8 for warning, bit 9 for passive and bit 10 for bus-off. Each of these is set in the same cycle the level first rises to or past it. Bit 11 is set by `msg_lost` and bit 15 by `mbox_evt`. Writing 1 clears a flag, and a set in the same cycle wins.
- R10: A cleared level flag is not raised again while the level stays where it is. It is raised again only on a new upward crossing.
- R11: `irq` is high when any flag is set whose bit is also set in the mask word (address 4, same bit positions). The mask word reads back as written.
- R12: In the cycle bus-off is entered, the mask word is cleared, so `irq` falls. A mask write in that same cycle is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_evt | input | 1 | Error detected pulse |
| err_is_tx | input | 1 | 1 when the error hit a frame being sent |
| err_code | input | 3 | Error type code, see R6 |
| tx_ok | input | 1 | Frame sent cleanly |
| rx_ok | input | 1 | Frame received cleanly |
| msg_lost | input | 1 | Received message lost pulse |
| mbox_evt | input | 1 | Mailbox event pulse |
| recover_req | input | 1 | Leave bus-off request |
| reg_addr | input | ADDR_W | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| tx_err_cnt | output | CNT_W | Transmit error count |
| rx_err_cnt | output | CNT_W | Receive error count |
| fault_state | output | 2 | Confinement level, see R4 |
| irq | output | 1 | Interrupt line |

## Verification
The assertions assume that every input is a known value from the first edge after reset. They also assume that each event input is high for exactly one clock per occurrence, so that a held level counts once per cycle. The bench drives every input from the falling clock edge with defined values only. Whenever it needs to move the counts without touching the status word, it uses error code 7. It always lowers a pulse before issuing a register access whose result it reads back.

// File: rtl/can_fault_pkg.sv
package can_fault_pkg;

  typedef enum logic [1:0] {
    FS_ACTIVE  = 2'd0,
    FS_WARNING = 2'd1,
    FS_PASSIVE = 2'd2,
    FS_BUSOFF  = 2'd3
  } fault_state_e;

  // status word: bits 16..18 levels, 19..24 error types
  localparam int unsigned ST_LSB = 16;
  localparam int unsigned ST_W   = 9;
  localparam int unsigned ERR_CODES = 6;

  // interrupt flags: warning, passive, bus-off, lost, mailbox
  localparam int unsigned IRQ_N = 5;
  localparam int unsigned IRQ_POS [IRQ_N] = '{8, 9, 10, 11, 15};

  function automatic int unsigned sat_add(int unsigned v, int unsigned step,
                                          int unsigned cap);
    return (v + step > cap) ? cap : v + step;
  endfunction

  function automatic int unsigned sat_dec(int unsigned v);
    return (v == 0) ? 0 : v - 1;
  endfunction

  function automatic fault_state_e grade(int unsigned tec, int unsigned rec,
                                         logic bo, int unsigned warn_lim,
                                         int unsigned pas_lim);
    if (bo) return FS_BUSOFF;
    if (tec >= pas_lim || rec >= pas_lim) return FS_PASSIVE;
    if (tec >= warn_lim || rec >= warn_lim) return FS_WARNING;
    return FS_ACTIVE;
  endfunction

  // error code -> status bit index (relative to ST_LSB); codes >= 6 map to nothing
  function automatic logic [ST_W-1:0] err_onehot(logic [2:0] code);
    logic [ST_W-1:0] r;
    r = '0;
    if (32'(code) < ERR_CODES) r[ST_W-1-32'(code)] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] irq_to_word(logic [IRQ_N-1:0] v);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < IRQ_N; i++) r[IRQ_POS[i]] = v[i];
    return r;
  endfunction

  function automatic logic [IRQ_N-1:0] word_to_irq(logic [31:0] w);
    logic [IRQ_N-1:0] r;
    for (int i = 0; i < IRQ_N; i++) r[i] = w[IRQ_POS[i]];
    return r;
  endfunction

endpackage

// File: rtl/fct_counters.sv
module fct_counters
  import can_fault_pkg::*;
#(
  parameter int unsigned CNT_W       = 9,
  parameter int unsigned WARN_LIM    = 96,
  parameter int unsigned PASSIVE_LIM = 128,
  parameter int unsigned BUSOFF_LIM  = 255,
  parameter int unsigned TX_ERR_INC  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_evt,
  input  logic             err_is_tx,
  input  logic             tx_ok,
  input  logic             rx_ok,
  input  logic             recover_req,
  output logic [CNT_W-1:0] tec_q,
  output logic [CNT_W-1:0] rec_q,
  output fault_state_e     state_now,
  output fault_state_e     state_next,
  output logic             busoff_entry
);

  localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

  logic [CNT_W-1:0] tec_d, rec_d;
  logic             bo_q, bo_d;
  int unsigned      tx_sum;

  always_comb begin
    tec_d  = tec_q;
    rec_d  = rec_q;
    bo_d   = bo_q;
    tx_sum = 32'(tec_q) + TX_ERR_INC;
    if (bo_q) begin
      if (recover_req) begin
        tec_d = '0;
        rec_d = '0;
        bo_d  = 1'b0;
      end
    end else if (err_evt) begin
      if (err_is_tx) begin
        tec_d = CNT_W'(sat_add(32'(tec_q), TX_ERR_INC, CNT_MAX));
        if (tx_sum > BUSOFF_LIM) bo_d = 1'b1;
      end else begin
        rec_d = CNT_W'(sat_add(32'(rec_q), 1, CNT_MAX));
      end
    end else begin
      if (tx_ok) tec_d = CNT_W'(sat_dec(32'(tec_q)));
      if (rx_ok) rec_d = CNT_W'(sat_dec(32'(rec_q)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tec_q <= '0;
      rec_q <= '0;
      bo_q  <= 1'b0;
    end else begin
      tec_q <= tec_d;
      rec_q <= rec_d;
      bo_q  <= bo_d;
    end
  end

  assign state_now    = grade(32'(tec_q), 32'(rec_q), bo_q, WARN_LIM, PASSIVE_LIM);
  assign state_next   = grade(32'(tec_d), 32'(rec_d), bo_d, WARN_LIM, PASSIVE_LIM);
  assign busoff_entry = bo_d & ~bo_q;

  assert_busoff_enter_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bo_q) |-> (32'(tec_q) > BUSOFF_LIM));

  assert_busoff_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bo_q && !recover_req |=> $stable(tec_q) && $stable(rec_q) && bo_q);

  assert_recover_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bo_q && recover_req |=> (tec_q == '0) && (rec_q == '0) && !bo_q);

  assert_tec_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bo_q && !err_evt && tx_ok && (tec_q == '0) |=> (tec_q == '0));

  assert_rec_ceiling_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bo_q && err_evt && !err_is_tx && (rec_q == '1) |=> (rec_q == '1));

endmodule

// File: rtl/fct_status.sv
module fct_status
  import can_fault_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            err_evt,
  input  logic [2:0]      err_code,
  input  fault_state_e    state_now,
  input  fault_state_e    state_next,
  input  logic [ST_W-1:0] clr,
  output logic [ST_W-1:0] sticky_q
);

  logic [ST_W-1:0] set_vec;

  always_comb begin
    set_vec    = err_evt ? err_onehot(err_code) : '0;
    set_vec[0] = set_vec[0] | (state_next >= FS_WARNING);
    set_vec[1] = set_vec[1] | (state_next >= FS_PASSIVE);
    set_vec[2] = set_vec[2] | (state_next == FS_BUSOFF);
  end

  for (genvar i = 0; i < ST_W; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= set_vec[i] | (bit_q & ~clr[i]);
    end
    assign sticky_q[i] = bit_q;
  end

  // code 3 must land on status bit 21 (index 5)
  assert_crc_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt && (err_code == 3'd3) |=> sticky_q[5]);

  assert_level_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_now >= FS_WARNING) |-> sticky_q[0]);

endmodule

// File: rtl/fct_irq.sv
module fct_irq
  import can_fault_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  fault_state_e     state_now,
  input  fault_state_e     state_next,
  input  logic             busoff_entry,
  input  logic             lost_evt,
  input  logic             mbox_evt,
  input  logic [IRQ_N-1:0] clr,
  input  logic             mask_we,
  input  logic [IRQ_N-1:0] mask_wd,
  output logic [IRQ_N-1:0] flags_q,
  output logic [IRQ_N-1:0] mask_q,
  output logic             irq
);

  logic [IRQ_N-1:0] set_vec;

  always_comb begin
    set_vec[0] = (state_next >= FS_WARNING) && (state_now < FS_WARNING);
    set_vec[1] = (state_next >= FS_PASSIVE) && (state_now < FS_PASSIVE);
    set_vec[2] = (state_next == FS_BUSOFF)  && (state_now != FS_BUSOFF);
    set_vec[3] = lost_evt;
    set_vec[4] = mbox_evt;
  end

  for (genvar i = 0; i < IRQ_N; i++) begin : g_flag
    logic f_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) f_q <= 1'b0;
      else        f_q <= set_vec[i] | (f_q & ~clr[i]);
    end
    assign flags_q[i] = f_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            mask_q <= '0;
    else if (busoff_entry) mask_q <= '0;
    else if (mask_we)      mask_q <= mask_wd;
  end

  assign irq = |(flags_q & mask_q);

  assert_busoff_mutes_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busoff_entry |=> (mask_q == '0) && !irq);

  assert_no_retrigger_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_next == state_now) && !flags_q[0] |=> !flags_q[0]);

  assert_irq_has_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags_q != '0) && (mask_q != '0));

endmodule

// File: rtl/can_fault_tracker.sv
module can_fault_tracker
  import can_fault_pkg::*;
#(
  parameter int unsigned CNT_W       = 9,
  parameter int unsigned WARN_LIM    = 96,
  parameter int unsigned PASSIVE_LIM = 128,
  parameter int unsigned BUSOFF_LIM  = 255,
  parameter int unsigned TX_ERR_INC  = 8,
  parameter int unsigned ADDR_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              err_evt,
  input  logic              err_is_tx,
  input  logic [2:0]        err_code,
  input  logic              tx_ok,
  input  logic              rx_ok,
  input  logic              msg_lost,
  input  logic              mbox_evt,
  input  logic              recover_req,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [CNT_W-1:0]  tx_err_cnt,
  output logic [CNT_W-1:0]  rx_err_cnt,
  output logic [1:0]        fault_state,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_TEC    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_REC    = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_FLAGS  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(4);

  logic [CNT_W-1:0] tec_q, rec_q;
  fault_state_e     st_now, st_next;
  logic             bo_entry;
  logic [ST_W-1:0]  st_clr, sticky_q;
  logic [IRQ_N-1:0] fl_clr, flags_q, mask_q, mask_wd;
  logic             mask_we;

  fct_counters #(
    .CNT_W(CNT_W), .WARN_LIM(WARN_LIM), .PASSIVE_LIM(PASSIVE_LIM),
    .BUSOFF_LIM(BUSOFF_LIM), .TX_ERR_INC(TX_ERR_INC)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .err_is_tx(err_is_tx),
    .tx_ok(tx_ok), .rx_ok(rx_ok), .recover_req(recover_req),
    .tec_q(tec_q), .rec_q(rec_q), .state_now(st_now), .state_next(st_next),
    .busoff_entry(bo_entry)
  );

  fct_status u_stat (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .err_code(err_code),
    .state_now(st_now), .state_next(st_next), .clr(st_clr),
    .sticky_q(sticky_q)
  );

  fct_irq u_irq (
    .clk(clk), .rst_n(rst_n), .state_now(st_now), .state_next(st_next),
    .busoff_entry(bo_entry), .lost_evt(msg_lost), .mbox_evt(mbox_evt),
    .clr(fl_clr), .mask_we(mask_we), .mask_wd(mask_wd),
    .flags_q(flags_q), .mask_q(mask_q), .irq(irq)
  );

  assign st_clr  = (reg_we && reg_addr == A_STATUS) ? reg_wdata[ST_LSB +: ST_W] : '0;
  assign fl_clr  = (reg_we && reg_addr == A_FLAGS) ? word_to_irq(reg_wdata) : '0;
  assign mask_we = reg_we && (reg_addr == A_MASK);
  assign mask_wd = word_to_irq(reg_wdata);

  always_comb begin
    case (reg_addr)
      A_STATUS: reg_rdata = 32'(sticky_q) << ST_LSB;
      A_TEC:    reg_rdata = 32'(tec_q);
      A_REC:    reg_rdata = 32'(rec_q);
      A_FLAGS:  reg_rdata = irq_to_word(flags_q);
      A_MASK:   reg_rdata = irq_to_word(mask_q);
      default:  reg_rdata = '0;
    endcase
  end

  assign tx_err_cnt  = tec_q;
  assign rx_err_cnt  = rec_q;
  assign fault_state = st_now;

endmodule

// File: tb/can_fault_tracker_bench.sv
`timescale 1ns/1ps
module can_fault_tracker_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        err_evt = 0, err_is_tx = 0, tx_ok = 0, rx_ok = 0;
  logic [2:0]  err_code = 3'd7;
  logic        msg_lost = 0, mbox_evt = 0, recover_req = 0;
  logic [2:0]  reg_addr = '0;
  logic        reg_we = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [8:0]  tx_err_cnt, rx_err_cnt;
  logic [1:0]  fault_state;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  can_fault_tracker u_can_fault_tracker (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .err_is_tx(err_is_tx),
    .err_code(err_code), .tx_ok(tx_ok), .rx_ok(rx_ok), .msg_lost(msg_lost),
    .mbox_evt(mbox_evt), .recover_req(recover_req), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_err_cnt(tx_err_cnt), .rx_err_cnt(rx_err_cnt),
    .fault_state(fault_state), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; err_evt = 0; err_is_tx = 0; err_code = 3'd7; tx_ok = 0;
    rx_ok = 0; msg_lost = 0; mbox_evt = 0; recover_req = 0; reg_we = 0;
    reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // hold an event pattern for n clock edges
  task automatic ev(int n, bit e, bit etx, bit [2:0] code, bit tok, bit rok);
    @(negedge clk);
    err_evt = e; err_is_tx = etx; err_code = code; tx_ok = tok; rx_ok = rok;
    repeat (n) @(negedge clk);
    err_evt = 0; err_is_tx = 0; err_code = 3'd7; tx_ok = 0; rx_ok = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    do_reset();
    chk("R1 tec", 32'(tx_err_cnt), 0);
    chk("R1 rec", 32'(rx_err_cnt), 0);
    chk("R1 state", 32'(fault_state), 0);
    chk("R1 irq", 32'(irq), 0);
    rd(3'd0, d); chk("R1 status", d, 0);
    rd(3'd3, d); chk("R1 flags", d, 0);
    rd(3'd4, d); chk("R1 mask", d, 0);
    rd(3'd5, d); chk("R8 unused addr 5", d, 0);
  endtask

  task automatic t_tx();
    do_reset();
    ev(3, 1, 1, 7, 0, 0);
    chk("R2 three tx errors", 32'(tx_err_cnt), 24);
    ev(2, 0, 0, 7, 1, 0);
    chk("R2 two tx ok", 32'(tx_err_cnt), 22);
    ev(1, 1, 1, 7, 1, 1);
    chk("R2 error wins over ok", 32'(tx_err_cnt), 30);
    ev(40, 0, 0, 7, 1, 0);
    chk("R2 floor at zero", 32'(tx_err_cnt), 0);
  endtask

  task automatic t_rx();
    logic [31:0] d;
    do_reset();
    ev(5, 1, 0, 7, 0, 0);
    chk("R3 five rx errors", 32'(rx_err_cnt), 5);
    ev(7, 0, 0, 7, 0, 1);
    chk("R3 rx ok floor", 32'(rx_err_cnt), 0);
    ev(520, 1, 0, 7, 0, 0);
    chk("R3 saturate", 32'(rx_err_cnt), 511);
    rd(3'd2, d); chk("R8 rec register", d, 511);
    chk("R4 passive from rec", 32'(fault_state), 2);
  endtask

  task automatic t_levels();
    logic [31:0] d;
    do_reset();
    ev(95, 1, 0, 7, 0, 0);
    chk("R4 below warning", 32'(fault_state), 0);
    rd(3'd3, d); chk("R9 no flag at 95", d, 0);
    ev(1, 1, 0, 7, 0, 0);
    chk("R4 warning at 96", 32'(fault_state), 1);
    rd(3'd3, d); chk("R9 warning flag", d, 32'h100);
    rd(3'd0, d); chk("R7 warning status", d, 32'h10000);
    wr(3'd3, 32'h100);
    rd(3'd3, d); chk("R9 flag cleared", d, 0);
    wr(3'd0, 32'h10000);
    rd(3'd0, d); chk("R7 held while level holds", d, 32'h10000);
    ev(1, 1, 0, 7, 0, 0);
    rd(3'd3, d); chk("R10 no retrigger", d, 0);
    ev(31, 1, 0, 7, 0, 0);
    chk("R4 passive at 128", 32'(fault_state), 2);
    rd(3'd3, d); chk("R9 passive flag", d, 32'h200);
    ev(33, 0, 0, 7, 0, 1);
    chk("R4 back to active", 32'(fault_state), 0);
    wr(3'd0, 32'h30000);
    rd(3'd0, d); chk("R7 clear after level drops", d, 0);
    wr(3'd3, 32'h200);
    ev(1, 1, 0, 7, 0, 0);
    rd(3'd3, d); chk("R10 new crossing raises again", d, 32'h100);
  endtask

  task automatic t_types();
    logic [31:0] d;
    logic [31:0] exp;
    do_reset();
    exp = 0;
    for (int c = 0; c < 6; c++) begin
      ev(1, 1, 0, 3'(c), 0, 0);
      exp = exp | (32'h1 << (24 - c));
      rd(3'd0, d); chk("R6 type bit", d, exp);
    end
    wr(3'd0, 32'h01F80000);
    rd(3'd0, d); chk("R7 clear type bits", d, 0);
    ev(1, 1, 0, 3'd6, 0, 0);
    ev(1, 1, 1, 3'd7, 0, 0);
    rd(3'd0, d); chk("R6 codes 6 and 7 set nothing", d, 0);
    chk("R6 invalid codes still count", 32'(rx_err_cnt), 7);
  endtask

  task automatic t_busoff();
    logic [31:0] d;
    do_reset();
    wr(3'd4, 32'h700);
    rd(3'd4, d); chk("R11 mask readback", d, 32'h700);
    ev(12, 1, 1, 7, 0, 0);
    chk("R2 tec 96", 32'(tx_err_cnt), 96);
    chk("R11 irq on warning", 32'(irq), 1);
    wr(3'd3, 32'h100);
    chk("R11 irq drops after clear", 32'(irq), 0);
    ev(19, 1, 1, 7, 0, 0);
    chk("R4 passive from tec", 32'(fault_state), 2);
    rd(3'd3, d); chk("R9 passive flag tx", d, 32'h200);
    @(negedge clk);
    err_evt = 1; err_is_tx = 1; reg_we = 1; reg_addr = 3'd4; reg_wdata = 32'h700;
    @(negedge clk);
    err_evt = 0; err_is_tx = 0; reg_we = 0;
    chk("R5 tec past limit", 32'(tx_err_cnt), 256);
    chk("R5 bus-off state", 32'(fault_state), 3);
    chk("R12 irq muted", 32'(irq), 0);
    rd(3'd4, d); chk("R12 mask cleared", d, 0);
    rd(3'd3, d); chk("R9 bus-off flag", d, 32'h600);
    rd(3'd0, d); chk("R7 all level bits", d, 32'h70000);
    ev(3, 0, 0, 7, 1, 0);
    ev(2, 1, 0, 7, 0, 0);
    ev(2, 1, 1, 7, 0, 0);
    chk("R5 tec frozen", 32'(tx_err_cnt), 256);
    chk("R5 rec frozen", 32'(rx_err_cnt), 0);
    @(negedge clk); recover_req = 1;
    @(negedge clk); recover_req = 0;
    chk("R5 recover tec", 32'(tx_err_cnt), 0);
    chk("R5 recover state", 32'(fault_state), 0);
    ev(1, 1, 1, 7, 0, 0);
    @(negedge clk); recover_req = 1;
    @(negedge clk); recover_req = 0;
    chk("R5 recover ignored when not bus-off", 32'(tx_err_cnt), 8);
  endtask

  task automatic t_misc();
    logic [31:0] d;
    do_reset();
    ev(2, 1, 1, 7, 0, 0);
    wr(3'd1, 32'hFF);
    wr(3'd2, 32'hFF);
    rd(3'd1, d); chk("R8 tec write ignored", d, 16);
    rd(3'd2, d); chk("R8 rec write ignored", d, 0);
    wr(3'd4, 32'h8000);
    @(negedge clk); msg_lost = 1;
    @(negedge clk); msg_lost = 0;
    rd(3'd3, d); chk("R9 lost flag", d, 32'h800);
    chk("R11 masked lost no irq", 32'(irq), 0);
    @(negedge clk); mbox_evt = 1;
    @(negedge clk); mbox_evt = 0;
    rd(3'd3, d); chk("R9 mailbox flag", d, 32'h8800);
    chk("R11 mailbox irq", 32'(irq), 1);
    wr(3'd3, 32'h8800);
    rd(3'd3, d); chk("R9 w1c flags", d, 0);
    chk("R11 irq idle", 32'(irq), 0);
    rd(3'd6, d); chk("R8 unused addr 6", d, 0);
  endtask

  initial begin
    t_reset();
    t_tx();
    t_rx();
    t_levels();
    t_types();
    t_busoff();
    t_misc();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule